// File: doc/BRIEF.md
# ATM Diagnostic Test Cell Generator

This block builds ATM test cells for a line-side loopback diagnostic and presents them one byte per transfer on a valid/ready stream. Each cell goes toward the transmit FIFO insertion point. Each cell opens with four programmable header bytes and one zero placeholder byte, which a later HEC stage overwrites. Forty-eight payload bytes follow. A free-running 15-bit pseudo-random sequence fills the payload. The sequence carries on across cell boundaries, so a receiver that checks the cells can lock onto it.

Generation runs while the enable input is 1. In continuous mode, cells follow each other with no gap. In one-shot mode, the block sends a burst of 1024 cells, stops, and raises a done flag. When enable is cleared, the cell in flight is finished before the block goes quiet. When enable is set again, done is cleared and a new burst count begins.

The control state machine has four states:
- IDLE: nothing is offered.
- HEADER: header bytes 1 to 4 are sent.
- HEC: the placeholder byte is sent.
- PAYLOAD: the pseudo-random bytes are sent.

Transitions:
- start: IDLE to HEADER, taken when enable is 1 and either done is 0 or enable has just risen.
- hdr_done: HEADER to HEC, on acceptance of header byte 4.
- hec_done: HEC to PAYLOAD, on acceptance of the placeholder byte.
- next_cell: PAYLOAD to HEADER, on acceptance of the last payload byte when enable is 1 and the burst is not complete.
- stop: PAYLOAD to IDLE, on acceptance of the last payload byte otherwise.

Top module: `atm_test_cell_gen`

## Requirements
- R1: After reset, out_valid and done are 0. While enable stays 0, out_valid stays 0.
- R2: A cell is 53 accepted bytes, in this order:
  - byte 0 is hdr_cfg[31:24];
  - byte 1 is hdr_cfg[23:16];
  - byte 2 is hdr_cfg[15:8];
  - byte 3 is hdr_cfg[7:0];
  - byte 4 is 0x00;
  - bytes 5 to 52 are payload.
  out_soc is 1 exactly while byte 0 is offered.
- R3: hdr_cfg is captured before the first byte of a cell. A change to hdr_cfg in the middle of a cell only affects the next cell.
- R4: Payload bytes come from a 15-bit register s, which resets to all ones.
  - Each byte takes 8 steps. Each step computes b = s[14]^s[13] and sets s = {s[13:0], b}.
  - The first new bit of a byte is its MSB.
  - s advances only when a payload byte is accepted, and it is never reseeded between cells or runs.
- R5: With one_shot at 1, exactly 1024 cells are sent after enable rises. Then out_valid goes to 0 and done goes to 1. done holds while enable stays 1, and also after enable falls.
- R6: In continuous mode (one_shot at 0) with out_ready held at 1, consecutive cells follow with no idle cycle. Cell starts are 53 cycles apart.
- R7: If enable is cleared partway through a cell, that cell is completed and out_valid then falls on a cell boundary.
- R8: A rising edge on enable clears done and restarts the burst count. A second one-shot run then sends a further 1024 cells.
- R9: While out_valid is 1 and out_ready is 0, out_data and out_soc hold their values. The byte position advances only on a transfer.
- R10: done stays 0 throughout continuous-mode runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control for the generator |
| one_shot | input | 1 | 1 selects the 1024-cell burst, 0 selects continuous mode |
| hdr_cfg | input | 32 | Header bytes 1..4; byte 1 in bits 31:24 |
| out_data | output | 8 | Cell byte offered |
| out_valid | output | 1 | A byte is offered |
| out_soc | output | 1 | The offered byte is the first byte of a cell |
| out_ready | input | 1 | The downstream side takes the byte |
| done | output | 1 | The one-shot burst has completed |

## Verification
The hardest conditions to reach from the ports are:
- the end of a full one-shot burst, which needs over 54,000 accepted bytes;
- a restart after that burst;
- a header change that lands between the header bytes of one cell.

The bench runs two complete one-shot bursts with ready held high. Before the second burst it lowers and then raises enable. A port-side byte counter lets the bench time the header change and the enable drop to particular byte positions. Table-driven runs apply periodic ready stall masks, so every byte crosses a backpressure cycle at some point.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HEADER  = 2'd1,
        ST_HEC     = 2'd2,
        ST_PAYLOAD = 2'd3
    } tcg_state_e;

    localparam int TCG_HDR_LEN  = 4;
    localparam int TCG_BYTE_W   = 8;

endpackage

// File: rtl/tcg_prbs.sv
module tcg_prbs #(
    parameter int          LEN    = 15,
    parameter int          TAP    = 14,
    parameter int          BYTE_W = 8,
    parameter logic [14:0] SEED   = 15'h7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [BYTE_W-1:0] byte_o
);

    logic [LEN-1:0] lfsr_q;
    logic [LEN-1:0] lfsr_nxt;

    always_comb begin
        logic fb;
        lfsr_nxt = lfsr_q;
        byte_o   = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            fb                 = lfsr_nxt[LEN-1] ^ lfsr_nxt[TAP-1];
            byte_o[BYTE_W-1-i] = fb;
            lfsr_nxt           = {lfsr_nxt[LEN-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED[LEN-1:0];
        end else if (advance) begin
            lfsr_q <= lfsr_nxt;
        end
    end

endmodule

// File: rtl/tcg_burst_ctr.sv
module tcg_burst_ctr #(
    parameter int N_CELLS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic cell_end,
    input  logic one_shot,
    output logic burst_last,
    output logic done_o
);

    localparam int CW = (N_CELLS > 1) ? $clog2(N_CELLS) : 1;
    localparam logic [CW-1:0] LAST = CW'(N_CELLS - 1);

    logic [CW-1:0] cnt_q;

    assign burst_last = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cell_end) begin
            cnt_q <= burst_last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o <= 1'b0;
        end else if (restart) begin
            done_o <= 1'b0;
        end else if (cell_end && one_shot && burst_last) begin
            done_o <= 1'b1;
        end
    end

endmodule

// File: rtl/tcg_fsm.sv
module tcg_fsm
    import tcg_pkg::*;
#(
    parameter int HDR_LEN  = 4,
    parameter int CELL_LEN = 53
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic                        en_rise,
    input  logic                        done,
    input  logic                        one_shot,
    input  logic                        burst_last,
    input  logic                        ready,
    output tcg_state_e                  state,
    output logic [$clog2(CELL_LEN)-1:0] idx,
    output logic                        valid,
    output logic                        soc,
    output logic                        accept,
    output logic                        cell_end
);

    localparam int IW = $clog2(CELL_LEN);
    localparam logic [IW-1:0] HDR_LAST  = IW'(HDR_LEN - 1);
    localparam logic [IW-1:0] CELL_LAST = IW'(CELL_LEN - 1);

    tcg_state_e     state_nxt;
    logic [IW-1:0]  idx_nxt;
    logic           start;
    logic           more;

    assign accept   = valid && ready;
    assign cell_end = accept && (state == ST_PAYLOAD) && (idx == CELL_LAST);
    assign start    = enable && (!done || en_rise);
    assign more     = enable && !(one_shot && burst_last);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nxt;
            idx   <= idx_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        unique case (state)
            ST_IDLE: begin
                idx_nxt = '0;
                if (start) begin
                    state_nxt = ST_HEADER;
                end
            end
            ST_HEADER: begin
                if (accept) begin
                    idx_nxt = idx + 1'b1;
                    if (idx == HDR_LAST) begin
                        state_nxt = ST_HEC;
                    end
                end
            end
            ST_HEC: begin
                if (accept) begin
                    idx_nxt   = idx + 1'b1;
                    state_nxt = ST_PAYLOAD;
                end
            end
            ST_PAYLOAD: begin
                if (accept) begin
                    if (idx == CELL_LAST) begin
                        idx_nxt   = '0;
                        state_nxt = more ? ST_HEADER : ST_IDLE;
                    end else begin
                        idx_nxt = idx + 1'b1;
                    end
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        valid = 1'b0;
        soc   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                valid = 1'b0;
            end
            ST_HEADER: begin
                valid = 1'b1;
                soc   = (idx == '0);
            end
            ST_HEC: begin
                valid = 1'b1;
            end
            ST_PAYLOAD: begin
                valid = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/atm_test_cell_gen.sv
module atm_test_cell_gen
    import tcg_pkg::*;
#(
    parameter int          N_CELLS     = 1024,
    parameter int          PAYLOAD_LEN = 48,
    parameter logic [7:0]  HEC_FILL    = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        one_shot,
    input  logic [31:0] hdr_cfg,
    output logic [7:0]  out_data,
    output logic        out_valid,
    output logic        out_soc,
    input  logic        out_ready,
    output logic        done
);

    localparam int CELL_LEN = TCG_HDR_LEN + 1 + PAYLOAD_LEN;
    localparam int IW       = $clog2(CELL_LEN);

    tcg_state_e     state;
    logic [IW-1:0]  idx;
    logic           accept;
    logic           cell_end;
    logic           burst_last;
    logic           en_q;
    logic           en_rise;
    logic [31:0]    hdr_q;
    logic [7:0]     prbs_byte;
    logic [7:0]     hdr_byte;

    assign en_rise = enable && !en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= enable;
        end
    end

    // header capture: open while idle and at each cell boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q <= '0;
        end else if (state == ST_IDLE || cell_end) begin
            hdr_q <= hdr_cfg;
        end
    end

    tcg_fsm #(
        .HDR_LEN  (TCG_HDR_LEN),
        .CELL_LEN (CELL_LEN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .en_rise    (en_rise),
        .done       (done),
        .one_shot   (one_shot),
        .burst_last (burst_last),
        .ready      (out_ready),
        .state      (state),
        .idx        (idx),
        .valid      (out_valid),
        .soc        (out_soc),
        .accept     (accept),
        .cell_end   (cell_end)
    );

    tcg_burst_ctr #(
        .N_CELLS (N_CELLS)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (en_rise),
        .cell_end   (cell_end),
        .one_shot   (one_shot),
        .burst_last (burst_last),
        .done_o     (done)
    );

    tcg_prbs #(
        .LEN    (15),
        .TAP    (14),
        .BYTE_W (TCG_BYTE_W),
        .SEED   (15'h7FFF)
    ) u_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (accept && (state == ST_PAYLOAD)),
        .byte_o  (prbs_byte)
    );

    always_comb begin
        hdr_byte = 8'h00;
        for (int b = 0; b < TCG_HDR_LEN; b++) begin
            if (idx == IW'(b)) begin
                hdr_byte = hdr_q[8*(TCG_HDR_LEN-1-b) +: 8];
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:    out_data = 8'h00;
            ST_HEADER:  out_data = hdr_byte;
            ST_HEC:     out_data = HEC_FILL;
            ST_PAYLOAD: out_data = prbs_byte;
        endcase
    end

endmodule

// File: rtl/atm_tcg_checker.sv
module atm_tcg_checker #(
    parameter int CELL_LEN = 53
) (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_soc,
    input logic       out_ready,
    input logic       done
);

    localparam int PW = $clog2(CELL_LEN);

    logic [PW-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (out_valid && out_ready) begin
            pos_q <= (pos_q == PW'(CELL_LEN - 1)) ? '0 : pos_q + 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && !out_valid |=> !out_valid);

    assert_soc_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_soc == (pos_q == '0)));

    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    assert_done_after_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid && out_ready));

    assert_stop_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> (pos_q == '0) && $past(out_ready));

    assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_soc));

endmodule

bind atm_test_cell_gen atm_tcg_checker #(
    .CELL_LEN (CELL_LEN)
) u_tcg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_soc   (out_soc),
    .out_ready (out_ready),
    .done      (done)
);

// File: tb/test_atm_test_cell_gen.sv
`timescale 1ns/1ps
module test_atm_test_cell_gen;

    localparam int N_CELLS  = 1024;
    localparam int CELL_LEN = 53;
    localparam int WD_LIMIT = 180000;

    // vectors: header, ready mask, cells to run, expected span (0 = not measured)
    localparam int NV = 4;
    localparam logic [31:0] V_HDR  [NV] = '{32'h0000_0010, 32'hA5C3_3C5A, 32'hFFEE_DDCC, 32'h1234_5678};
    localparam logic [7:0]  V_RDY  [NV] = '{8'hFF, 8'b1011_0111, 8'b0101_0101, 8'hFF};
    localparam int          V_RUN  [NV] = '{2, 2, 1, 3};
    localparam int          V_SPAN [NV] = '{2*CELL_LEN, 0, 0, 3*CELL_LEN};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        one_shot = 1'b0;
    logic [31:0] hdr_cfg = 32'h0;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_soc;
    logic        out_ready;
    logic        done;

    logic [7:0]  rdy_mask = 8'hFF;
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    // reference model state
    int          m_pos = 0;
    logic [14:0] m_lfsr = 15'h7FFF;
    logic [31:0] m_hdr = 32'h0;
    int          cells_seen = 0;
    int          soc_count = 0;
    int          last_soc_cyc = 0;

    always #4 clk = ~clk;

    atm_test_cell_gen #(.N_CELLS(N_CELLS)) i_atm_test_cell_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .one_shot  (one_shot),
        .hdr_cfg   (hdr_cfg),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_soc   (out_soc),
        .out_ready (out_ready),
        .done      (done)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [22:0] prbs_step(input logic [14:0] s);
        logic [7:0] b;
        logic       nb;
        for (int i = 0; i < 8; i++) begin
            nb       = s[14] ^ s[13];
            b[7-i]   = nb;
            s        = {s[13:0], nb};
        end
        return {s, b};
    endfunction

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
        end
        #1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
        end
    end

    // ready driver from the current mask
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            out_ready = rdy_mask[cyc % 8];
        end
    end

    // byte monitor on accepted transfers
    initial begin
        logic [22:0] r;
        logic [7:0]  exp_b;
        forever begin
            @(negedge clk);
            if (rst_n && out_valid && out_ready) begin
                if (m_pos == 0) begin
                    m_hdr = hdr_cfg;
                    soc_count++;
                    last_soc_cyc = cyc;
                end
                check(out_soc == (m_pos == 0), "R2 soc position", out_soc, m_pos == 0);
                if (m_pos < 4) begin
                    exp_b = m_hdr[8*(3-m_pos) +: 8];
                    check(out_data == exp_b, "R2/R3 header byte", out_data, exp_b);
                end else if (m_pos == 4) begin
                    check(out_data == 8'h00, "R2 placeholder byte", out_data, 0);
                end else begin
                    r = prbs_step(m_lfsr);
                    check(out_data == r[7:0], "R4 payload byte", out_data, r[7:0]);
                    m_lfsr = r[22:8];
                end
                m_pos++;
                if (m_pos == CELL_LEN) begin
                    m_pos = 0;
                    cells_seen++;
                end
            end
        end
    end

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            if (cyc > WD_LIMIT) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WD_LIMIT);
                report();
            end
        end
    end

    task automatic wait_not_valid();
        while (out_valid) tick(1);
    endtask

    task automatic wait_pos(input int p);
        while (!(out_valid && m_pos == p)) tick(1);
    endtask

    initial begin
        int base;
        int t0;

        // R1: reset state and quiet while disabled
        tick(3);
        check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        check(done == 1'b0, "R1 done in reset", done, 0);
        rst_n = 1'b1;
        tick(10);
        check(out_valid == 1'b0, "R1 valid while disabled", out_valid, 0);

        // table of continuous runs (R6, R9, R10, R7)
        for (int v = 0; v < NV; v++) begin
            hdr_cfg  = V_HDR[v];
            rdy_mask = V_RDY[v];
            one_shot = 1'b0;
            base     = soc_count;
            enable   = 1'b1;
            while (soc_count < base + 1) tick(1);
            t0 = last_soc_cyc;
            while (soc_count < base + 1 + V_RUN[v]) tick(1);
            if (V_SPAN[v] != 0) begin
                check(last_soc_cyc - t0 == V_SPAN[v], "R6 back-to-back span",
                      last_soc_cyc - t0, V_SPAN[v]);
            end
            enable = 1'b0;
            wait_not_valid();
            tick(1);
            check(m_pos == 0, "R7 stop on cell boundary", m_pos, 0);
            check(done == 1'b0, "R10 done in continuous", done, 0);
            tick(5);
            check(out_valid == 1'b0, "R1 quiet after disable", out_valid, 0);
        end
        rdy_mask = 8'hFF;

        // R3: header change in the middle of the header bytes
        hdr_cfg = 32'h1111_2222;
        enable  = 1'b1;
        base    = cells_seen;
        wait_pos(2);
        hdr_cfg = 32'h3333_4444;
        while (cells_seen < base + 2) tick(1);
        check(m_hdr == 32'h3333_4444, "R3 next cell takes new header", m_hdr, 32'h3333_4444);

        // R7: enable dropped mid-cell
        wait_pos(10);
        base   = cells_seen;
        enable = 1'b0;
        wait_not_valid();
        tick(1);
        check(cells_seen == base + 1, "R7 cell completed", cells_seen, base + 1);
        check(m_pos == 0, "R7 boundary", m_pos, 0);

        // R5: one-shot burst
        one_shot = 1'b1;
        base     = cells_seen;
        enable   = 1'b1;
        while (!done) tick(1);
        tick(2);
        check(cells_seen - base == N_CELLS, "R5 burst length", cells_seen - base, N_CELLS);
        check(out_valid == 1'b0, "R5 quiet after burst", out_valid, 0);
        tick(20);
        check(out_valid == 1'b0 && done == 1'b1, "R5 stays stopped", {out_valid, done}, 2'b01);
        enable = 1'b0;
        tick(3);
        check(done == 1'b1, "R5 done holds after enable falls", done, 1);

        // R8: restart clears done and counts a new burst
        base   = cells_seen;
        enable = 1'b1;
        tick(2);
        check(done == 1'b0, "R8 done cleared on restart", done, 0);
        check(out_valid == 1'b1, "R8 generation restarted", out_valid, 1);
        while (!done) tick(1);
        tick(2);
        check(cells_seen - base == N_CELLS, "R8 second burst length", cells_seen - base, N_CELLS);
        enable = 1'b0;
        tick(5);

        report();
    end

endmodule